// File: doc/BRIEF.md
# ISA Interrupt Request Mask and Vector Unit

This block collects sixteen ISA interrupt request lines and merges them into a single processor interrupt output. Each line has a pending bit and an enable bit. The output is raised while any line is both pending and enabled. Software sees the sixteen lines as two byte-wide register ports, one for lines 0-7 and one for lines 8-15, laid out like a pair of cascaded interrupt controllers. Each port has two offsets. Offset 0 acknowledges: any write clears the pending bits of that port's byte. Offset 1 holds the mask: the written byte is stored inverted, so a 1 disables the line.

A third select reads a 32-bit vector register. It returns the number of the lowest line that is both pending and enabled. A pending bit follows a rising request edge and drops whenever its line falls. Software acknowledges by writing offset 0. A line that stays high after an acknowledge stays clear until it deasserts and rises again. Reads are combinational from the current state and have no side effects.

Top module: `isa_irq_mask_unit`

## Requirements
- R1: A rising edge on request line i, taken from the line's value at one clock edge compared with its value at the previous edge, sets pending bit i at that clock edge.
- R2: `cpuIrq` is 1 exactly when (pending AND enable) is nonzero.
- R3: A write with `busSel`=0 and `busOff`=1 stores the bitwise complement of `busWrData` into enable bits 7:0 and leaves bits 15:8 unchanged.
- R4: A write with `busSel`=1 and `busOff`=1 stores the bitwise complement of `busWrData` into enable bits 15:8 and leaves bits 7:0 unchanged.
- R5: A read with `busSel` 0 or 1 and `busOff`=1 returns the 16-bit enable mask in `busRdData` bits 15:0, with bits 31:16 zero.
- R6: Any write with `busOff`=0 clears pending bits 7:0 when `busSel`=0 and pending bits 15:8 when `busSel`=1, whatever the data. The other byte is left as it was.
- R7: When a rising request edge and a clearing write for the same line fall in the same cycle, the pending bit ends up set.
- R8: At each clock edge where a request line is low, its pending bit becomes 0.
- R9: After reset the enable mask is 0xFFFF and all pending bits are 0.
- R10: A read with `busSel`=2 returns the index of the lowest set bit of (pending AND enable), zero-extended to 32 bits. It returns 0 when no such bit is set.
- R11: A read with `busOff`=0 on select 0 or 1 returns 0, and so does any read with `busSel`=3. Writes with `busSel` 2 or 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqIn | input | 16 | ISA interrupt request lines, active high |
| busWr | input | 1 | Write strobe for the register bus |
| busSel | input | 2 | 0 low port, 1 high port, 2 vector register, 3 unused |
| busOff | input | 1 | Register offset within a port |
| busWrData | input | 8 | Write data byte |
| busRdData | output | 32 | Combinational read data |
| cpuIrq | output | 1 | Processor interrupt request |

## Verification
A wrong pending or enable bit shows up at the ports within one cycle. It appears as a wrong `cpuIrq` level, and a read of select 2 gives a different vector number. A mask that is wrong in one byte can be read back at offset 1 of either port in the cycle after the write. Two hazards are exercised directly: a clear that lands together with a new request edge, and a line that is still held high after its acknowledge. Both would otherwise stay hidden until a later interrupt went missing or arrived twice.

// File: rtl/isa_irq_pkg.sv
package isa_irq_pkg;
  localparam int PORT_CNT = 2;
  localparam int PORT_W   = 8;

  typedef struct packed {
    logic [PORT_CNT-1:0] clrPort;
    logic [PORT_CNT-1:0] mskPort;
    logic                rdMask;
    logic                rdVec;
  } strobe_t;
endpackage

// File: rtl/isa_irq_ctrl.sv
module isa_irq_ctrl
  import isa_irq_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             busWr,
  input  logic [SEL_W-1:0] busSel,
  input  logic             busOff,
  output strobe_t          strobes
);
  logic [PORT_CNT-1:0] hitPort;

  for (genvar p = 0; p < PORT_CNT; p++) begin : g_port
    assign hitPort[p]            = (busSel == SEL_W'(p));
    assign strobes.clrPort[p]    = busWr && hitPort[p] && !busOff;
    assign strobes.mskPort[p]    = busWr && hitPort[p] && busOff;
  end

  assign strobes.rdMask = (|hitPort) && busOff;
  assign strobes.rdVec  = (busSel == SEL_W'(PORT_CNT));
endmodule

// File: rtl/isa_irq_datapath.sv
module isa_irq_datapath
  import isa_irq_pkg::*;
#(
  parameter int VEC_W = 32,
  localparam int NUM_LINES = PORT_CNT * PORT_W,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] reqIn,
  input  logic [PORT_W-1:0]    busWrData,
  input  strobe_t              strobes,
  output logic [VEC_W-1:0]     busRdData,
  output logic                 cpuIrq,
  output logic [NUM_LINES-1:0] pendingQ,
  output logic [NUM_LINES-1:0] enableQ,
  output logic [NUM_LINES-1:0] reqPrevQ,
  output logic [IDX_W-1:0]     vecIdx
);
  logic [NUM_LINES-1:0] riseVec;
  logic [NUM_LINES-1:0] clrMask;
  logic [NUM_LINES-1:0] enableD;
  logic [NUM_LINES-1:0] activeVec;

  assign riseVec = reqIn & ~reqPrevQ;

  for (genvar p = 0; p < PORT_CNT; p++) begin : g_byte
    assign clrMask[p*PORT_W +: PORT_W] = {PORT_W{strobes.clrPort[p]}};
    assign enableD[p*PORT_W +: PORT_W] = strobes.mskPort[p] ? ~busWrData
                                                            : enableQ[p*PORT_W +: PORT_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPrevQ <= '0;
      pendingQ <= '0;
      enableQ  <= '1;
    end else begin
      reqPrevQ <= reqIn;
      pendingQ <= ((pendingQ & ~clrMask) | riseVec) & reqIn;
      enableQ  <= enableD;
    end
  end

  assign activeVec = pendingQ & enableQ;
  assign cpuIrq    = |activeVec;

  always_comb begin
    vecIdx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (activeVec[i]) vecIdx = IDX_W'(i);
    end
  end

  always_comb begin
    busRdData = '0;
    if (strobes.rdVec)       busRdData = VEC_W'(vecIdx);
    else if (strobes.rdMask) busRdData = VEC_W'(enableQ);
  end
endmodule

// File: rtl/isa_irq_mask_unit.sv
module isa_irq_mask_unit
  import isa_irq_pkg::*;
#(
  parameter int VEC_W = 32,
  localparam int NUM_LINES = PORT_CNT * PORT_W,
  localparam int SEL_W = $clog2(PORT_CNT + 1),
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] reqIn,
  input  logic                 busWr,
  input  logic [SEL_W-1:0]     busSel,
  input  logic                 busOff,
  input  logic [PORT_W-1:0]    busWrData,
  output logic [VEC_W-1:0]     busRdData,
  output logic                 cpuIrq
);
  strobe_t              strobes;
  logic [NUM_LINES-1:0] pendingQ;
  logic [NUM_LINES-1:0] enableQ;
  logic [NUM_LINES-1:0] reqPrevQ;
  logic [IDX_W-1:0]     vecIdx;

  isa_irq_ctrl #(.SEL_W(SEL_W)) i_ctrl (
    .busWr   (busWr),
    .busSel  (busSel),
    .busOff  (busOff),
    .strobes (strobes)
  );

  isa_irq_datapath #(.VEC_W(VEC_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqIn     (reqIn),
    .busWrData (busWrData),
    .strobes   (strobes),
    .busRdData (busRdData),
    .cpuIrq    (cpuIrq),
    .pendingQ  (pendingQ),
    .enableQ   (enableQ),
    .reqPrevQ  (reqPrevQ),
    .vecIdx    (vecIdx)
  );
endmodule

// File: rtl/isa_irq_checker.sv
module isa_irq_checker #(
  parameter int N = 16,
  parameter int IW = 4,
  parameter int SW = 2,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic [N-1:0]  reqIn,
  input logic          busWr,
  input logic [SW-1:0] busSel,
  input logic          busOff,
  input logic [BW-1:0] busWrData,
  input logic          cpuIrq,
  input logic [N-1:0]  pendingQ,
  input logic [N-1:0]  enableQ,
  input logic [N-1:0]  reqPrevQ,
  input logic [IW-1:0] vecIdx
);
  // R8: a low line leaves no pending bit behind
  assert_low_line_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ & ~$past(reqIn)) == '0);

  // R3: low port mask write stores the complement
  assert_mask_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busSel == SW'(0) && busOff) |=>
      (enableQ[BW-1:0] == ~$past(busWrData)) && $stable(enableQ[N-1:BW]));

  // R4: high port mask write stores the complement
  assert_mask_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busSel == SW'(1) && busOff) |=>
      (enableQ[N-1:BW] == ~$past(busWrData)) && $stable(enableQ[BW-1:0]));

  // R6: low acknowledge clears every low bit not newly raised
  assert_clear_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busSel == SW'(0) && !busOff) |=>
      (pendingQ[BW-1:0] & ~$past(reqIn[BW-1:0] & ~reqPrevQ[BW-1:0])) == '0);

  // R1 and R7: a rising edge always lands in pending, even against a clear
  assert_rise_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((reqIn & ~reqPrevQ) != '0) |=>
      ((pendingQ & $past(reqIn & ~reqPrevQ)) == $past(reqIn & ~reqPrevQ)));

  // R2 and R10: output low means the vector reads zero; high means it names a live line
  assert_irq_vector_R10: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq |-> (pendingQ[vecIdx] && enableQ[vecIdx]));
  assert_idle_vector_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cpuIrq |-> (vecIdx == '0));
endmodule

bind isa_irq_mask_unit isa_irq_checker #(
  .N(NUM_LINES), .IW(IDX_W), .SW(SEL_W), .BW(isa_irq_pkg::PORT_W)
) i_checker (
  .clk(clk), .rstN(rstN), .reqIn(reqIn), .busWr(busWr), .busSel(busSel),
  .busOff(busOff), .busWrData(busWrData), .cpuIrq(cpuIrq),
  .pendingQ(pendingQ), .enableQ(enableQ), .reqPrevQ(reqPrevQ), .vecIdx(vecIdx)
);

// File: tb/test_isa_irq_mask_unit.sv
module test_isa_irq_mask_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] reqIn = '0;
  logic        busWr = 1'b0;
  logic [1:0]  busSel = '0;
  logic        busOff = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [31:0] busRdData;
  logic        cpuIrq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit          isIrq;
    logic [31:0] expVal;
    string       tag;
  } item_t;
  item_t expQ[$];

  always #4 clk = ~clk;

  isa_irq_mask_unit i_isa_irq_mask_unit (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .busWr(busWr), .busSel(busSel),
    .busOff(busOff), .busWrData(busWrData), .busRdData(busRdData), .cpuIrq(cpuIrq)
  );

  // monitor: compares outputs 2 ns after each falling edge
  always @(negedge clk) begin
    #2;
    while (expQ.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = expQ.pop_front();
      act = it.isIrq ? {31'b0, cpuIrq} : busRdData;
      checks++;
      if (act !== it.expVal) begin
        failures++;
        $display("FAIL %s actual=0x%08h expected=0x%08h", it.tag, act, it.expVal);
      end
    end
  end

  task automatic setReq(input logic [15:0] v);
    @(negedge clk);
    busWr = 1'b0;
    reqIn = v;
  endtask

  task automatic wrReg(input logic [1:0] sel, input logic off, input logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busSel = sel; busOff = off; busWrData = d;
  endtask

  task automatic wrWithReq(input logic [1:0] sel, input logic off, input logic [15:0] v);
    @(negedge clk);
    busWr = 1'b1; busSel = sel; busOff = off; busWrData = 8'h5A; reqIn = v;
  endtask

  task automatic chkRead(input logic [1:0] sel, input logic off,
                         input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    busWr = 1'b0; busSel = sel; busOff = off;
    it.isIrq = 1'b0; it.expVal = e; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic chkIrq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    busWr = 1'b0;
    it.isIrq = 1'b1; it.expVal = {31'b0, e}; it.tag = tag;
    expQ.push_back(it);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9 reset state
    chkRead(2'd0, 1'b1, 32'h0000_FFFF, "R9 mask after reset");
    chkIrq(1'b0, "R9 no irq after reset");
    chkRead(2'd2, 1'b0, 32'd0, "R10 vector none pending");
    // R1 rising edge on line 4
    setReq(16'h0010);
    chkIrq(1'b1, "R1 R2 line4 raises irq");
    chkRead(2'd2, 1'b0, 32'd4, "R10 vector line4");
    setReq(16'h0110);
    chkRead(2'd2, 1'b0, 32'd4, "R10 lowest wins over line8");
    // R3 mask line 4 via low port
    wrReg(2'd0, 1'b1, 8'h10);
    chkRead(2'd1, 1'b1, 32'h0000_FFEF, "R3 R5 mask via high port read");
    chkRead(2'd2, 1'b0, 32'd8, "R10 masked line skipped");
    chkIrq(1'b1, "R2 line8 still active");
    // R6 acknowledge low byte while line4 held high
    wrReg(2'd0, 1'b0, 8'h00);
    wrReg(2'd0, 1'b1, 8'h00);
    chkRead(2'd0, 1'b1, 32'h0000_FFFF, "R3 unmask low");
    chkRead(2'd2, 1'b0, 32'd8, "R6 low cleared, high kept");
    wrReg(2'd1, 1'b0, 8'hFF);
    chkIrq(1'b0, "R6 high cleared");
    chkRead(2'd2, 1'b0, 32'd0, "R6 R10 nothing pending");
    // R8 deassert clears
    setReq(16'h0000);
    setReq(16'h0004);
    chkRead(2'd2, 1'b0, 32'd2, "R1 line2 pending");
    setReq(16'h0000);
    chkIrq(1'b0, "R8 deassert clears");
    // R4 mask high byte
    wrReg(2'd1, 1'b1, 8'hFF);
    chkRead(2'd0, 1'b1, 32'h0000_00FF, "R4 high mask stored inverted");
    setReq(16'h8000);
    chkIrq(1'b0, "R2 masked line15 silent");
    chkRead(2'd2, 1'b0, 32'd0, "R10 masked gives zero");
    wrReg(2'd1, 1'b1, 8'h7F);
    chkIrq(1'b1, "R4 R2 unmask line15");
    chkRead(2'd2, 1'b0, 32'd15, "R10 vector line15");
    // R7 same-cycle clear and new edge
    wrReg(2'd1, 1'b1, 8'h00);
    wrWithReq(2'd1, 1'b0, 16'hC000);
    chkRead(2'd2, 1'b0, 32'd14, "R7 new edge survives clear");
    chkIrq(1'b1, "R7 irq kept");
    // R11 offset 0, select 3 and ignored writes
    chkRead(2'd0, 1'b0, 32'd0, "R11 low offset0 reads zero");
    chkRead(2'd1, 1'b0, 32'd0, "R11 high offset0 reads zero");
    chkRead(2'd3, 1'b1, 32'd0, "R11 select3 reads zero");
    wrReg(2'd2, 1'b1, 8'hFF);
    wrReg(2'd3, 1'b0, 8'hFF);
    chkRead(2'd1, 1'b1, 32'h0000_FFFF, "R11 writes to sel2/3 keep mask");
    chkRead(2'd2, 1'b0, 32'd14, "R11 writes to sel2/3 keep pending");
    // line 0 active: irq high, vector 0
    setReq(16'h0000);
    setReq(16'h0001);
    chkIrq(1'b1, "R2 line0 raises irq");
    chkRead(2'd2, 1'b0, 32'd0, "R10 vector line0");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule